// File: doc/BRIEF.md
# Write-Twice Protected Disable Register

This block is a single software-visible control register that holds the shutdown controls for a timestamp engine and its sub-units. One bit shuts down the whole engine together with its configuration registers. One further bit per sub-unit shuts down that sub-unit and its local configuration registers. A mistaken write must not be able to switch anything off, so a bit only sets after software has written a 1 to it on two register writes in a row. Writing a 0 cancels a half-finished sequence, and it also clears a bit that is already set.

The bus side has one address. It takes a single-cycle write strobe with address and data, and it returns read data combinationally for the addressed location. Each disable bit is driven from its own flop. Active-low enables for each sub-unit and for its configuration registers are derived from these bits. A sub-unit counts as enabled only when neither its own bit nor the global bit is set.

Top module: `twp_disable_reg`

## Requirements
- R1: A disable bit is 0 after the first write of 1 at the register address and becomes 1 after the second consecutive write of 1, visible in the cycle after that second write strobe.
- R2: A write of 0 to a bit whose sequence is half done cancels it, so that the next single write of 1 leaves the bit at 0.
- R3: A write of 0 to a bit that is set clears it in the cycle after the write.
- R4: Clock cycles with no write strobe between the two writes of 1 do not break the sequence.
- R5: A write strobe at any address other than the register address changes neither the disable bits nor any half-done sequence.
- R6: Each bit follows the two-write rule independently of the others within the same write word.
- R7: A read at the register address returns the global bit at data bit 0 and sub-unit k's bit at data bit k+1, with all other data bits 0. A half-done sequence is not visible in the read. A read at any other address returns 0.
- R8: Synchronous active-low reset clears all disable bits and all half-done sequences.
- R9: A sub-unit's active-low enable and its configuration-register enable are both 1 when the sub-unit's bit or the global bit is set, and 0 otherwise. The global configuration enable is 1 exactly when the global bit is set.
- R10: Writing 1 to a bit that is already set leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the current address |
| glb_dis_o | output | 1 | Global disable bit |
| glb_csr_en_n_o | output | 1 | Active-low enable for the engine's configuration registers |
| unit_dis_o | output | NUM_UNITS | Per-sub-unit disable bits |
| unit_en_n_o | output | NUM_UNITS | Active-low enable for each sub-unit |
| unit_csr_en_n_o | output | NUM_UNITS | Active-low enable for each sub-unit's local configuration registers |

## Verification
On every cycle, the assertions check the local rules of each bit. A bit can only rise on an addressed write of 1 that found its sequence half done. An addressed write of 0 clears the bit and its sequence. A cycle without an addressed write leaves both untouched. A bit and its half-done flag are never 1 together. Only the bench scenarios can show the orderings that span several writes: the exact write on which each bit sets, the bits running independently inside one word, idle gaps and foreign-address writes falling between the two writes, the read mapping, the way the enables combine, and reset in the middle of a sequence.

// File: rtl/twp_pkg.sv
// Package: shared constants and helpers for the write-twice disable register.
// Assumes the global disable bit sits at register bit 0 and sub-units follow it.
package twp_pkg;

    // Register bit that holds the global disable.
    localparam int unsigned GLB_BIT = 0;

    // Register bit index of sub-unit k's disable.
    function automatic int unsigned unit_bit(input int unsigned k);
        return k + 1;
    endfunction

    // Number of register bits used for a given number of sub-units.
    function automatic int unsigned reg_bits(input int unsigned units);
        return units + 1;
    endfunction

endpackage

// File: rtl/twp_addr_dec.sv
// Module: twp_addr_dec
// Decodes the bus address against the single register address. It produces a
// write-hit qualifier and a read-hit qualifier.
// Assumes: wr_en is a single-cycle strobe; reads are combinational.
module twp_addr_dec #(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_hit,
    output logic              rd_hit
);

    // Compare the address once and qualify it with the write strobe.
    always_comb begin
        rd_hit = (addr == REG_ADDR);
        wr_hit = wr_en && rd_hit;
    end

endmodule

// File: rtl/twp_arm_cell.sv
// Module: twp_arm_cell
// One protected disable bit. It has a one-bit arm flag that records the first
// write of 1. The second addressed write of 1 sets the bit. An addressed write
// of 0 clears both the bit and the arm flag.
// Assumes: wr_hit is high only for writes to this register.
module twp_arm_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wbit,
    output logic dis_q,
    output logic pend_q
);

    // Advance the write-twice sequence on each addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (wr_hit) begin
            if (!wbit) begin
                dis_q  <= 1'b0;
                pend_q <= 1'b0;
            end else if (!dis_q) begin
                if (pend_q) begin
                    dis_q  <= 1'b1;
                    pend_q <= 1'b0;
                end else begin
                    pend_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/twp_out_map.sv
// Module: twp_out_map
// Derives the per-sub-unit active-low enables from the registered disable
// bits. Either the sub-unit's own bit or the global bit shuts the sub-unit down.
// Assumes: bit GLB_BIT is the global disable; sub-unit k sits at unit_bit(k).
module twp_out_map
    import twp_pkg::*;
#(
    parameter int unsigned NUM_UNITS = 4,
    localparam int unsigned NB = NUM_UNITS + 1
) (
    input  logic [NB-1:0]        dis_q,
    output logic                 glb_dis,
    output logic                 glb_csr_en_n,
    output logic [NUM_UNITS-1:0] unit_dis,
    output logic [NUM_UNITS-1:0] unit_en_n,
    output logic [NUM_UNITS-1:0] unit_csr_en_n
);

    // Global outputs come straight from the global bit.
    always_comb begin
        glb_dis      = dis_q[GLB_BIT];
        glb_csr_en_n = dis_q[GLB_BIT];
    end

    // Per-sub-unit enables combine the sub-unit's bit with the global bit.
    for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
        always_comb begin
            unit_dis[k]      = dis_q[unit_bit(k)];
            unit_en_n[k]     = dis_q[unit_bit(k)] | dis_q[GLB_BIT];
            unit_csr_en_n[k] = dis_q[unit_bit(k)] | dis_q[GLB_BIT];
        end
    end

endmodule

// File: rtl/twp_disable_reg.sv
// Module: twp_disable_reg (top)
// Write-twice protected disable register for a timestamp engine and its
// sub-units. Each bit has its own arm cell. Reads return only the disable bits.
// Assumes: DATA_W > NUM_UNITS + 1; single-cycle write strobe; sync reset.
module twp_disable_reg
    import twp_pkg::*;
#(
    parameter int unsigned NUM_UNITS = 4,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 glb_dis_o,
    output logic                 glb_csr_en_n_o,
    output logic [NUM_UNITS-1:0] unit_dis_o,
    output logic [NUM_UNITS-1:0] unit_en_n_o,
    output logic [NUM_UNITS-1:0] unit_csr_en_n_o
);

    localparam int unsigned NB = reg_bits(NUM_UNITS);

    logic          wr_hit;
    logic          rd_hit;
    logic [NB-1:0] dis_q;
    logic [NB-1:0] pend_q;
    logic          unused_hi;

    // Upper write-data bits carry no control.
    assign unused_hi = ^wr_data[DATA_W-1:NB];

    twp_addr_dec #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_dec (
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bit
        twp_arm_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_hit),
            .wbit   (wr_data[b]),
            .dis_q  (dis_q[b]),
            .pend_q (pend_q[b])
        );
    end

    twp_out_map #(
        .NUM_UNITS (NUM_UNITS)
    ) u_map (
        .dis_q         (dis_q),
        .glb_dis       (glb_dis_o),
        .glb_csr_en_n  (glb_csr_en_n_o),
        .unit_dis      (unit_dis_o),
        .unit_en_n     (unit_en_n_o),
        .unit_csr_en_n (unit_csr_en_n_o)
    );

    // Read mux: disable bits only at the register address, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (rd_hit) rd_data[NB-1:0] = dis_q;
    end

endmodule

// File: rtl/twp_disable_reg_chk.sv
// Module: twp_disable_reg_chk
// Per-cycle checks on every bit's write-twice sequence. It is bound into the
// top module.
// Assumes: synchronous active-low reset held for at least one clock at start.
module twp_disable_reg_chk #(
    parameter int unsigned NB = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_hit,
    input logic [NB-1:0] wd,
    input logic [NB-1:0] dis_q,
    input logic [NB-1:0] pend_q
);

    for (genvar b = 0; b < NB; b++) begin : g_chk
        // R1
        rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dis_q[b]) |-> ($past(wr_hit) && $past(wd[b]) && $past(pend_q[b])));
        // R2
        zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && !wd[b]) |=> (!dis_q[b] && !pend_q[b]));
        // R5
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_hit |=> ($stable(dis_q[b]) && $stable(pend_q[b])));
        // R10
        set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && wd[b] && dis_q[b]) |=> dis_q[b]);
        // R7
        arm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(dis_q[b] && pend_q[b]));
    end

endmodule

bind twp_disable_reg twp_disable_reg_chk #(.NB(NB)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wd     (wr_data[NB-1:0]),
    .dis_q  (dis_q),
    .pend_q (pend_q)
);

// File: tb/twp_disable_reg_tb.sv
`timescale 1ns/1ps
module twp_disable_reg_tb;

    localparam int unsigned NU = 4;
    localparam int unsigned NB = NU + 1;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 32;
    localparam logic [AW-1:0] RA = 8'h24;
    localparam logic [AW-1:0] OA = 8'h10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = RA;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          glb_dis_o, glb_csr_en_n_o;
    logic [NU-1:0] unit_dis_o, unit_en_n_o, unit_csr_en_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twp_disable_reg #(.NUM_UNITS(NU), .ADDR_W(AW), .DATA_W(DW), .REG_ADDR(RA)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .glb_dis_o(glb_dis_o), .glb_csr_en_n_o(glb_csr_en_n_o),
        .unit_dis_o(unit_dis_o), .unit_en_n_o(unit_en_n_o),
        .unit_csr_en_n_o(unit_csr_en_n_o)
    );

    // Vector: {address, write bits, expected disable bits after the write}.
    localparam int NV = 13;
    localparam logic [AW+2*NB-1:0] VEC [NV] = '{
        {RA, 5'b00001, 5'b00000},  // R1 first write: not yet set
        {RA, 5'b00001, 5'b00001},  // R1 second write: set
        {RA, 5'b00011, 5'b00001},  // R10 bit0 held, R6 bit1 armed only
        {OA, 5'b00000, 5'b00001},  // R5 foreign address, nothing moves
        {RA, 5'b00010, 5'b00010},  // R3 bit0 cleared, bit1 still armed and sets
        {RA, 5'b00100, 5'b00000},  // R3 bit1 cleared, bit2 armed
        {RA, 5'b00000, 5'b00000},  // R2 arm of bit2 cancelled
        {RA, 5'b00100, 5'b00000},  // R2 restart needs two writes
        {RA, 5'b00100, 5'b00100},  // R1 set
        {RA, 5'b11000, 5'b00000},  // R6 bit2 cleared, bits 3 and 4 armed
        {RA, 5'b01000, 5'b01000},  // R6 bit3 sets, bit4 arm cancelled
        {RA, 5'b10000, 5'b00000},  // R2 bit4 re-armed from scratch
        {RA, 5'b10000, 5'b10000}   // R2 bit4 sets
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One write strobe; outputs are sampled at the next falling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr = RA; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Check every output against an expected set of disable bits (R7, R9).
    task automatic chk_all(input string req, input logic [NB-1:0] e);
        logic [NU-1:0] en;
        en = e[NB-1:1] | {NU{e[0]}};
        addr = RA;
        #0.1;
        chk(req, rd_data, {{(DW-NB){1'b0}}, e});
        chk(req, {31'b0, glb_dis_o}, {31'b0, e[0]});
        chk(req, {31'b0, glb_csr_en_n_o}, {31'b0, e[0]});
        chk(req, {28'b0, unit_dis_o}, {28'b0, e[NB-1:1]});
        chk(req, {28'b0, unit_en_n_o}, {28'b0, en});
        chk(req, {28'b0, unit_csr_en_n_o}, {28'b0, en});
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R8 reset state
        chk_all("R8", '0);

        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][AW+2*NB-1 -: AW], {{(DW-NB){1'b0}}, VEC[v][2*NB-1 -: NB]});
            chk_all($sformatf("R1/R6 vec%0d", v), VEC[v][NB-1:0]);
        end

        // R4 idle gap between the two writes of 1
        do_reset();
        wr(RA, 32'h2);
        idle(6);
        chk_all("R4", 5'b00000);
        wr(RA, 32'h2);
        chk_all("R4", 5'b00010);

        // R5 foreign-address write of 0 between the two writes of 1
        wr(RA, 32'h6);
        wr(OA, 32'h0);
        chk_all("R5", 5'b00010);
        wr(RA, 32'h6);
        chk_all("R5", 5'b00110);

        // R7 read at another address returns zero; armed bit invisible
        addr = OA; #0.1;
        chk("R7", rd_data, '0);
        wr(RA, 32'h10);
        chk_all("R7", 5'b00000);

        // R9 global bit shuts every sub-unit
        do_reset();
        wr(RA, 32'h1); wr(RA, 32'h1);
        chk_all("R9", 5'b00001);
        addr = RA; #0.1;
        chk("R9", {28'b0, unit_en_n_o}, 32'hF);

        // R8 reset in mid sequence drops the arm
        wr(RA, 32'h8);
        do_reset();
        chk_all("R8", 5'b00000);
        wr(RA, 32'h8);
        chk_all("R8", 5'b00000);
        wr(RA, 32'h8);
        chk_all("R8", 5'b01000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule